// File: doc/BRIEF.md
# Modem Status Change Interrupt

This block watches the four modem control inputs of a serial port (clear-to-send, data-set-ready, data-carrier-detect and ring indicator). It brings each raw pin into the clock domain and keeps one sticky change flag per line. From those flags it produces a single level-type modem-status interrupt request. The pins are active low. The current state of each line is reported active high, so a 1 means the line is asserted.

Software reads the change flags and line states through the surrounding register logic. That logic pulses `status_rd` when the status register is read, and the pulse clears all four flags together. When automatic CTS flow control is on, the transmitter handles CTS by itself. In that mode a CTS change still records its flag, but it raises the interrupt only if a separate CTS interrupt enable is also set. Changes on the other three lines are never affected by this mask.

The interrupt path is a two-state machine:
- **IRQ_IDLE**: the request is low.
- **IRQ_RAISED**: the request is high.

The machine has two transitions:
- **IDLE to RAISED** (`raise`) is taken in the cycle after an enabled cause appears.
- **RAISED to IDLE** (`drop`) is taken in the cycle after the cause goes away, either because the flags were cleared or because an enable was removed.

Each line has its own change detector. Each detector is either an any-edge detector or a trailing-edge detector.

Top module: `msc_modem_irq`

## Requirements
- R1: After reset, `delta_o`, `line_state_o` and `irq_o` are all 0.
- R2: `line_state_o[k]` equals the inverse of line k's pin, delayed by the two-flop synchroniser. Bit 0 is CTS, bit 1 is DSR, bit 2 is RI and bit 3 is DCD.
- R3: Any change of the CTS pin sets `delta_o[0]`, including while automatic CTS flow control is on.
- R4: A change of the DSR pin in either direction sets `delta_o[1]`. A change of the DCD pin in either direction sets `delta_o[3]`.
- R5: `delta_o[2]` is set only when RI goes from asserted to released (pin low to high). A release-to-assert change leaves the flag unchanged.
- R6: Change flags stay set until a cycle with `status_rd` high. That read clears all four flags at the next clock edge.
- R7: A change that is detected in the same cycle as a read keeps its flag set after that read.
- R8: `irq_o` is never raised while `ms_irq_en` is 0.
- R9: With `ms_irq_en`=1 and `auto_cts_en`=0, any set flag raises `irq_o` one cycle later.
- R10: With `ms_irq_en`=1 and `auto_cts_en`=1, a CTS flag on its own raises `irq_o` only when `cts_irq_en`=1.
- R11: With `ms_irq_en`=1 and `auto_cts_en`=1, a set DSR, RI or DCD flag raises `irq_o` whatever the value of `cts_irq_en`.
- R12: `irq_o` is a level. It stays high until its causing flags are cleared or its enables are removed, and it falls one cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_pin_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_pin_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_pin_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_pin_n | input | 1 | Data-carrier-detect pin, active low, asynchronous |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| auto_cts_en | input | 1 | Automatic CTS flow control is active |
| cts_irq_en | input | 1 | CTS interrupt enable, used only while auto CTS is on |
| status_rd | input | 1 | Strobe marking a read of the modem status register |
| delta_o | output | 4 | Sticky change flags: CTS, DSR, RI trailing edge, DCD (bit 0 to bit 3) |
| line_state_o | output | 4 | Synchronised line states, active high, same bit order |
| irq_o | output | 1 | Modem-status interrupt request, level |

## Verification
The hardest case to reach from the ports is a change that lands in exactly the cycle of a status read. The edge is only visible internally, for one cycle, two clock edges after the pin moves. To hit it, the bench changes the pin half a cycle before an edge, counts two rising edges, and then raises `status_rd` for the following cycle. An older flag on another line is set beforehand, so the same read shows both outcomes: the old flag is cleared while the new change keeps its flag. The masking cases are reached by leaving a CTS flag pending and then toggling `cts_irq_en` and adding a DCD change while auto CTS stays on.

// File: rtl/msc_modem_irq_pkg.sv
package msc_modem_irq_pkg;

    localparam int unsigned NUM_LINES = 4;
    localparam int unsigned SYNC_STAGES = 2;

    localparam int unsigned LN_CTS = 0;
    localparam int unsigned LN_DSR = 1;
    localparam int unsigned LN_RI  = 2;
    localparam int unsigned LN_DCD = 3;

    typedef enum logic {
        EDGE_ANY   = 1'b0,
        EDGE_TRAIL = 1'b1
    } edge_kind_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/msc_change_det.sv
module msc_change_det
    import msc_modem_irq_pkg::*;
#(
    parameter edge_kind_e EDGE    = EDGE_ANY,
    parameter logic       RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clear_i,
    output logic flag_o
);
    logic prev_q;
    logic flag_q;
    logic hit;

    generate
        if (EDGE == EDGE_TRAIL) begin : g_trail
            // pin low (asserted) to high (released)
            assign hit = !prev_q && level_i;
        end else begin : g_any
            assign hit = prev_q != level_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
            flag_q <= 1'b0;
        end else begin
            prev_q <= level_i;
            flag_q <= hit | (flag_q & ~clear_i);
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/msc_irq_fsm.sv
module msc_irq_fsm
    import msc_modem_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] flags_i,
    input  logic                 ms_irq_en,
    input  logic                 auto_cts_en,
    input  logic                 cts_irq_en,
    output logic                 irq_o
);
    irq_state_e state_q, state_d;
    logic       cts_cause;
    logic       other_cause;
    logic       cause;

    always_comb begin
        cts_cause   = flags_i[LN_CTS] & (~auto_cts_en | cts_irq_en);
        other_cause = flags_i[LN_DSR] | flags_i[LN_RI] | flags_i[LN_DCD];
        cause       = ms_irq_en & (cts_cause | other_cause);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (cause)  state_d = IRQ_RAISED;   // raise
            IRQ_RAISED: if (!cause) state_d = IRQ_IDLE;     // drop
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/msc_modem_irq.sv
module msc_modem_irq
    import msc_modem_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cts_pin_n,
    input  logic                 dsr_pin_n,
    input  logic                 ri_pin_n,
    input  logic                 dcd_pin_n,
    input  logic                 ms_irq_en,
    input  logic                 auto_cts_en,
    input  logic                 cts_irq_en,
    input  logic                 status_rd,
    output logic [NUM_LINES-1:0] delta_o,
    output logic [NUM_LINES-1:0] line_state_o,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] sync_n;
    logic [NUM_LINES-1:0] flags;

    assign pins_n = {dcd_pin_n, ri_pin_n, dsr_pin_n, cts_pin_n};

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            localparam edge_kind_e KIND = (i == LN_RI) ? EDGE_TRAIL : EDGE_ANY;

            msc_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_VAL (1'b1)
            ) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (pins_n[i]),
                .sync_o  (sync_n[i])
            );

            msc_change_det #(
                .EDGE    (KIND),
                .RST_VAL (1'b1)
            ) u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .level_i (sync_n[i]),
                .clear_i (status_rd),
                .flag_o  (flags[i])
            );
        end
    endgenerate

    msc_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags_i     (flags),
        .ms_irq_en   (ms_irq_en),
        .auto_cts_en (auto_cts_en),
        .cts_irq_en  (cts_irq_en),
        .irq_o       (irq_o)
    );

    assign delta_o      = flags;
    assign line_state_o = ~sync_n;
endmodule

// File: rtl/msc_modem_irq_chk.sv
module msc_modem_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ms_irq_en,
    input logic       auto_cts_en,
    input logic       cts_irq_en,
    input logic       status_rd,
    input logic [3:0] delta_o,
    input logic [3:0] line_state_o,
    input logic       irq_o
);
    AST_DISABLED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_irq_en |=> !irq_o); // R8

    AST_AUTO_CTS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_irq_en && auto_cts_en && !cts_irq_en && delta_o[3:1] == 3'b000) |=> !irq_o); // R10

    AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_irq_en && !auto_cts_en && delta_o != 4'b0000) |=> irq_o); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((delta_o & $past(delta_o)) == $past(delta_o))); // R6

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && line_state_o == $past(line_state_o)) |=> delta_o == 4'b0000); // R6

    AST_CTS_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state_o[0] != $past(line_state_o[0])) |=> delta_o[0]); // R3

    AST_RI_LEADING_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!delta_o[2] && !(!line_state_o[2] && $past(line_state_o[2]))) |=> !delta_o[2]); // R5
endmodule

bind msc_modem_irq msc_modem_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_irq_en    (ms_irq_en),
    .auto_cts_en  (auto_cts_en),
    .cts_irq_en   (cts_irq_en),
    .status_rd    (status_rd),
    .delta_o      (delta_o),
    .line_state_o (line_state_o),
    .irq_o        (irq_o)
);

// File: tb/msc_modem_irq_bench.sv
`timescale 1ns/1ps
module msc_modem_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_pin_n = 1'b1, dsr_pin_n = 1'b1, ri_pin_n = 1'b1, dcd_pin_n = 1'b1;
    logic       ms_irq_en = 1'b0, auto_cts_en = 1'b0, cts_irq_en = 1'b0, status_rd = 1'b0;
    logic [3:0] delta_o;
    logic [3:0] line_state_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msc_modem_irq u_msc_modem_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_pin_n    (cts_pin_n),
        .dsr_pin_n    (dsr_pin_n),
        .ri_pin_n     (ri_pin_n),
        .dcd_pin_n    (dcd_pin_n),
        .ms_irq_en    (ms_irq_en),
        .auto_cts_en  (auto_cts_en),
        .cts_irq_en   (cts_irq_en),
        .status_rd    (status_rd),
        .delta_o      (delta_o),
        .line_state_o (line_state_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_status();
        status_rd = 1'b1;
        step(1);
        status_rd = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 delta", delta_o, 4'b0000);
        chk("R1 line", line_state_o, 4'b0000);
        chk("R1 irq", {3'b0, irq_o}, 4'b0000);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic t_dsr_level();
        ms_irq_en = 1'b0;
        dsr_pin_n = 1'b0;
        step(1);
        chk("R2 latency", line_state_o, 4'b0000);
        step(4);
        chk("R2 line", line_state_o, 4'b0010);
        chk("R4 dsr fall", delta_o, 4'b0010);
        chk("R8 irq off", {3'b0, irq_o}, 4'b0000);
        ms_irq_en = 1'b1;
        step(2);
        chk("R9 irq on", {3'b0, irq_o}, 4'b0001);
        step(10);
        chk("R12 irq held", {3'b0, irq_o}, 4'b0001);
        chk("R6 sticky", delta_o, 4'b0010);
        read_status();
        chk("R6 cleared", delta_o, 4'b0000);
        step(1);
        chk("R12 irq drop", {3'b0, irq_o}, 4'b0000);
        dsr_pin_n = 1'b1;
        step(5);
        chk("R4 dsr rise", delta_o, 4'b0010);
        read_status();
        step(2);
    endtask

    task automatic t_ri();
        ri_pin_n = 1'b0;
        step(5);
        chk("R5 ri lead", delta_o, 4'b0000);
        chk("R5 ri lead irq", {3'b0, irq_o}, 4'b0000);
        chk("R2 ri line", line_state_o, 4'b0100);
        ri_pin_n = 1'b1;
        step(5);
        chk("R5 ri trail", delta_o, 4'b0100);
        chk("R9 ri irq", {3'b0, irq_o}, 4'b0001);
        read_status();
        step(2);
    endtask

    task automatic t_auto_cts();
        auto_cts_en = 1'b1;
        cts_irq_en  = 1'b0;
        cts_pin_n   = 1'b0;
        step(6);
        chk("R3 cts flag auto", delta_o, 4'b0001);
        chk("R10 cts masked", {3'b0, irq_o}, 4'b0000);
        cts_irq_en = 1'b1;
        step(2);
        chk("R10 cts unmasked", {3'b0, irq_o}, 4'b0001);
        cts_irq_en = 1'b0;
        step(2);
        chk("R12 mask drops irq", {3'b0, irq_o}, 4'b0000);
        dcd_pin_n = 1'b0;
        step(6);
        chk("R4 dcd fall", delta_o, 4'b1001);
        chk("R11 dcd under auto", {3'b0, irq_o}, 4'b0001);
        ms_irq_en = 1'b0;
        step(2);
        chk("R12 enable removed", {3'b0, irq_o}, 4'b0000);
        chk("R6 flags kept", delta_o, 4'b1001);
        ms_irq_en = 1'b1;
        read_status();
        step(2);
        chk("R6 read clears all", delta_o, 4'b0000);
    endtask

    task automatic t_same_cycle();
        dcd_pin_n = 1'b1;
        step(5);
        chk("R4 dcd rise", delta_o, 4'b1000);
        cts_pin_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        status_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        status_rd = 1'b0;
        chk("R7 change in read cycle", delta_o, 4'b0001);
        step(1);
        chk("R7 irq masked cts", {3'b0, irq_o}, 4'b0000);
        auto_cts_en = 1'b0;
        step(2);
        chk("R9 cts irq no auto", {3'b0, irq_o}, 4'b0001);
        read_status();
        step(2);
        chk("R6 final clear", delta_o, 4'b0000);
        chk("R12 final irq", {3'b0, irq_o}, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_dsr_level();
        t_ri();
        t_auto_cts();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule